// File: doc/BRIEF.md
# Overcurrent Fault Supervisor with Timed Release

This block watches three digital inputs of a three-phase gate-drive controller: an overcurrent comparator flag, a low-side supply undervoltage flag and a gate enable. From them it produces one registered kill signal, which forces every gate output off, and one registered active-low fault indication.

An overcurrent flag counts only once it has stayed high for a minimum number of clock cycles. A qualified trip sets a hold latch in which the set input wins. The latch is released only after the filtered trip has gone away and a recharge timer has then counted up to a programmable threshold. That timer stands in for an external capacitor: it is reset to zero by every qualified trip and counts only while no trip is present. The undervoltage flag drives the fault output directly, with no memory. The enable input has its own filter, and while it is low it forces kill without raising a fault.

Top module: `oc_fault_guard`

## Requirements
- R1: During reset and just after it, `fault_n_o` is 1, `kill_o` is 1 (the filtered enable starts low), and the recharge timer sits at its threshold, so the block holds no fault.
- R2: An overcurrent pulse of fewer than `TRIP_FILT_CYC` consecutive high cycles has no effect. `fault_n_o` stays 1 and `kill_o` stays 0. Such a pulse that arrives while the timer is counting does not restart it.
- R3: An overcurrent flag held high for `TRIP_FILT_CYC` cycles or longer drives `fault_n_o` to 0 and `kill_o` to 1 exactly `TRIP_FILT_CYC`+2 clock edges after it rises.
- R4: The set input of the hold latch dominates. While the filtered trip stays high the latch stays set and the timer stays at zero, however long the trip lasts.
- R5: After the flag falls, `fault_n_o` is still 0 at edge `TRIP_FILT_CYC`+`CLEAR_CYC`+1 and becomes 1 at edge `TRIP_FILT_CYC`+`CLEAR_CYC`+2. `kill_o` returns to 0 at the same edge if enable and supply are good.
- R6: A new qualified trip while the timer is counting sets the timer back to zero and keeps the latch set. The release is then measured from the end of the new trip.
- R7: The recharge timer saturates at `CLEAR_CYC` and never exceeds it, so a long idle period does not change the release time of a later trip.
- R8: `uv_flag_i` high drives `fault_n_o` to 0 and `kill_o` to 1 one edge later. Its fall releases them one edge later with no delay. It neither sets nor clears the overcurrent latch.
- R9: Enable passes through a symmetric filter of `EN_FILT_CYC` cycles. A filtered low forces `kill_o` to 1 one edge after the filter output changes, and leaves `fault_n_o` at 1. An enable glitch shorter than `EN_FILT_CYC` cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| oc_flag_i | input | 1 | Overcurrent comparator output, high = over limit |
| uv_flag_i | input | 1 | Low-side undervoltage flag, high = supply too low |
| en_i | input | 1 | Gate enable, high = outputs allowed |
| kill_o | output | 1 | Registered shutdown of all gate outputs, high = off |
| fault_n_o | output | 1 | Registered fault indication, active low |

## Verification
The bench sweeps overcurrent pulse widths just below the filter length and at several widths from the filter length upward. A filter that is off by one either trips on a three-cycle glitch or misses an exact-length pulse. Each release is checked one cycle before and on the exact release edge, for short and very long trips. A timer that runs during the trip, or that is not reset on a trip, releases early. The bench retriggers during the countdown, where a design that only sets the latch releases at the old time. It also sends sub-filter glitches during the countdown, where a design that restarts on the raw flag releases late. Undervoltage is checked for immediate release except while a trip is latched. Enable glitches are checked so that a one-sided or missing filter leaves kill asserted.

// File: rtl/ocg_pkg.sv
package ocg_pkg;
  // Width of a counter that must hold values 0..limit.
  function automatic int cnt_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/ocg_rst_sync.sv
module ocg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/ocg_deglitch.sv
module ocg_deglitch #(
  parameter int LEN  = 4,
  parameter bit INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  import ocg_pkg::*;

  generate
    if (LEN <= 1) begin : g_direct
      logic out_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= INIT;
        else        out_q <= din;
      end
      assign dout = out_q;
    end else begin : g_count
      localparam int CW = cnt_bits(LEN - 1);
      localparam logic [CW-1:0] LAST = CW'(LEN - 1);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          out_q, out_d;

      always_comb begin
        cnt_d = cnt_q;
        out_d = out_q;
        if (din == out_q) begin
          cnt_d = '0;
        end else if (cnt_q == LAST) begin
          cnt_d = '0;
          out_d = din;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          out_q <= INIT;
        end else begin
          cnt_q <= cnt_d;
          out_q <= out_d;
        end
      end
      assign dout = out_q;
    end
  endgenerate

  // The output may only move towards a value the input held on the prior cycle.
  assert_filter_follows_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> ($past(din) == dout));
endmodule

// File: rtl/ocg_trip_hold.sv
module ocg_trip_hold #(
  parameter int CLEAR_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_f,
  output logic held_o
);
  import ocg_pkg::*;

  localparam int TW = cnt_bits(CLEAR_CYC);
  localparam logic [TW-1:0] FULL = TW'(CLEAR_CYC);

  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;
  logic          held_q, held_d;
  logic          at_full;

  assign at_full = (tmr_q == FULL);

  always_comb begin
    tmr_en = trip_f | ~at_full;
    tmr_d  = trip_f ? '0 : tmr_q + 1'b1;
    held_d = trip_f | (held_q & ~at_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= FULL;
      held_q <= 1'b0;
    end else begin
      if (tmr_en) tmr_q <= tmr_d;
      held_q <= held_d;
    end
  end

  assign held_o = held_q;

  assert_timer_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q <= FULL);
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_f |=> (held_q && tmr_q == '0));
  assert_release_after_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_q) |-> ($past(tmr_q) == FULL && !$past(trip_f)));
  assert_retrigger_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && trip_f) |=> (tmr_q == '0 && held_q));
endmodule

// File: rtl/oc_fault_guard.sv
module oc_fault_guard #(
  parameter int TRIP_FILT_CYC = 46,
  parameter int EN_FILT_CYC   = 120,
  parameter int CLEAR_CYC     = 380000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_flag_i,
  input  logic uv_flag_i,
  input  logic en_i,
  output logic kill_o,
  output logic fault_n_o
);
  logic rst_s_n;
  logic trip_f, en_f, held;
  logic kill_q, kill_d, fault_n_q, fault_n_d;

  ocg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  ocg_deglitch #(.LEN(TRIP_FILT_CYC), .INIT(1'b0)) u_trip_filt (
    .clk(clk), .rst_n(rst_s_n), .din(oc_flag_i), .dout(trip_f)
  );

  ocg_deglitch #(.LEN(EN_FILT_CYC), .INIT(1'b0)) u_en_filt (
    .clk(clk), .rst_n(rst_s_n), .din(en_i), .dout(en_f)
  );

  ocg_trip_hold #(.CLEAR_CYC(CLEAR_CYC)) u_hold (
    .clk(clk), .rst_n(rst_s_n), .trip_f(trip_f), .held_o(held)
  );

  always_comb begin
    fault_n_d = ~(held | uv_flag_i);
    kill_d    = held | uv_flag_i | ~en_f;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      kill_q    <= 1'b1;
      fault_n_q <= 1'b1;
    end else begin
      kill_q    <= kill_d;
      fault_n_q <= fault_n_d;
    end
  end

  assign kill_o    = kill_q;
  assign fault_n_o = fault_n_q;

  assert_latched_trip_outputs_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    held |=> (kill_o && !fault_n_o));
  assert_uv_fault_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    uv_flag_i |=> (!fault_n_o && kill_o));
  assert_enable_kill_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !en_f |=> kill_o);
  assert_fault_implies_kill_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    !fault_n_o |-> kill_o);
endmodule

// File: tb/oc_fault_guard_test.sv
`timescale 1ns/1ps
module oc_fault_guard_test;
  localparam int TF = 4;
  localparam int EF = 6;
  localparam int CL = 20;
  localparam int REL = TF + CL + 2;

  logic clk = 1'b0;
  logic rst_n, oc, uv, en;
  logic kill, fault_n;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  oc_fault_guard #(.TRIP_FILT_CYC(TF), .EN_FILT_CYC(EF), .CLEAR_CYC(CL)) uut (
    .clk(clk), .rst_n(rst_n), .oc_flag_i(oc), .uv_flag_i(uv), .en_i(en),
    .kill_o(kill), .fault_n_o(fault_n)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Trip with a pulse of w cycles, then follow it to release.
  task automatic trip_cycle(input string tag, input int w);
    oc = 1'b1;
    for (int c = 1; c <= w + REL; c++) begin
      step(1);
      if (c == w) oc = 1'b0;
      if (c == TF + 1) chk(tag, "fault_n before qualify", fault_n, 1'b1);
      if (c == TF + 2) begin
        chk(tag, "fault_n on trip", fault_n, 1'b0);
        chk(tag, "kill on trip", kill, 1'b1);
      end
      if (c == w && w > TF + 2) chk("R4", "fault_n held during long trip", fault_n, 1'b0);
      if (c == w + REL - 1) chk("R5", "fault_n one edge before release", fault_n, 1'b0);
      if (c == w + REL) begin
        chk("R5", "fault_n at release", fault_n, 1'b1);
        chk("R5", "kill at release", kill, 1'b0);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; oc = 1'b0; uv = 1'b0; en = 1'b0;
    step(3);
    chk("R1", "fault_n in reset", fault_n, 1'b1);
    chk("R1", "kill in reset", kill, 1'b1);
    rst_n = 1'b1;
    step(3);
    chk("R1", "fault_n after reset", fault_n, 1'b1);
    chk("R1", "kill after reset", kill, 1'b1);

    en = 1'b1;
    step(EF);
    chk("R9", "kill before enable qualifies", kill, 1'b1);
    step(1);
    chk("R9", "kill after enable qualifies", kill, 1'b0);

    // R2: sub-filter pulses
    for (int w = 1; w < TF; w++) begin
      oc = 1'b1; step(w); oc = 1'b0;
      for (int k = 0; k < TF + 4; k++) begin
        step(1);
        chk("R2", "fault_n after short pulse", fault_n, 1'b1);
        chk("R2", "kill after short pulse", kill, 1'b0);
      end
    end

    // R3/R4/R5: sweep of qualifying widths
    trip_cycle("R3", TF);
    trip_cycle("R3", TF + 1);
    trip_cycle("R3", TF + 7);
    trip_cycle("R4", 3 * CL);

    // R6: retrigger during countdown
    oc = 1'b1; step(TF); oc = 1'b0;
    step(10);
    oc = 1'b1; step(TF); oc = 1'b0;
    for (int c = 1; c <= REL; c++) begin
      step(1);
      chk("R6", "fault_n after retrigger", fault_n, (c >= REL) ? 1'b1 : 1'b0);
    end

    // R2: sub-filter glitch during countdown leaves the timer running
    oc = 1'b1; step(TF); oc = 1'b0;
    step(8);
    oc = 1'b1; step(TF - 1); oc = 1'b0;
    for (int c = 8 + TF; c <= REL; c++) begin
      step(1);
      chk("R2", "fault_n with glitch in countdown", fault_n, (c >= REL) ? 1'b1 : 1'b0);
    end

    // R7: long idle, then the release time is unchanged
    step(2 * CL + 10);
    chk("R7", "fault_n after long idle", fault_n, 1'b1);
    trip_cycle("R7", TF);

    // R8: undervoltage follows directly
    uv = 1'b1; step(1);
    chk("R8", "fault_n on uv", fault_n, 1'b0);
    chk("R8", "kill on uv", kill, 1'b1);
    step(4);
    chk("R8", "fault_n during uv", fault_n, 1'b0);
    uv = 1'b0; step(1);
    chk("R8", "fault_n uv gone", fault_n, 1'b1);
    chk("R8", "kill uv gone", kill, 1'b0);
    // R8: uv ending does not release a held trip
    oc = 1'b1; step(TF); oc = 1'b0;
    step(2);
    uv = 1'b1; step(3); uv = 1'b0; step(1);
    chk("R8", "fault_n held trip after uv", fault_n, 1'b0);
    step(REL - 6 - 1);
    chk("R8", "fault_n before trip release", fault_n, 1'b0);
    step(1);
    chk("R8", "fault_n trip release", fault_n, 1'b1);

    // R9: enable low and glitch
    en = 1'b0; step(EF);
    chk("R9", "kill before disable qualifies", kill, 1'b0);
    step(1);
    chk("R9", "kill disabled", kill, 1'b1);
    chk("R9", "fault_n while disabled", fault_n, 1'b1);
    en = 1'b1; step(EF + 1);
    chk("R9", "kill re-enabled", kill, 1'b0);
    en = 1'b0; step(EF - 1); en = 1'b1;
    for (int k = 0; k < EF + 4; k++) begin
      step(1);
      chk("R9", "kill after enable glitch", kill, 1'b0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule